// File: doc/BRIEF.md
# Cascaded Second-Order Audio Filter Engine

This block filters one channel's audio stream. Each accepted sample is first multiplied by a programmable input gain. It then passes through a chain of second-order recursive sections. Each section keeps its own two past inputs and two past outputs.

Every section has five 20-bit coefficients held as signed fractions. Three of them are stored in an offset or halved form, so that every stored value lies in [-1, +1):
- the feed-forward gain with one subtracted,
- half of the first feed-forward tap,
- half of the first feedback tap.

The datapath restores the unity term and the doubling itself. A single shared multiply-accumulate unit evaluates the gain stage and then each section in turn. The result appears on an output strobe a fixed number of cycles after the input strobe.

Coefficients and the gain are loaded through a plain write port. A write is honoured only while the engine is idle. A write that arrives during a computation is dropped, so a sample is never filtered with a mix of old and new values.

Top module: `biq_cascade`

## Requirements
- R1: After reset, `out_valid` is low, `out_sample` is 0, and every coefficient and the gain register read as zero. With a zero gain, any sample produces an output of 0.
- R2: Coefficient k (0..4) of section s sits at write address 5*s+k. The gain register sits at address 5*NSEC (20 by default). Writes to any higher address have no effect.
- R3: The section-0 input is f = sat(floor(-((-g)·x) / 2^19)), where x is the sample and g is the signed gain. A gain of 80000h gives the full input with its sign inverted. A gain of 0 gives no input.
- R4: Section s works in units of 2^-19 with coefficient k0=b2, k1=b0-1, k2=a2, k3=a1/2, k4=b1/2. It computes acc = f·2^19 + k1·f + 2·k4·x1 + k0·x2 − 2·k3·y1 − k2·y2 and y = sat(floor(acc / 2^19)).
- R5: The sections form a cascade. The output of section s is the input of section s+1, and the last section's output is the block output. After every sample, each section shifts its own input and output history by one.
- R6: Both the gain result and every section output saturate to [-8388608, 8388607] instead of wrapping.
- R7: `out_valid` is a one-cycle pulse exactly 5*NSEC+2 (22) rising edges after the edge that accepted `in_valid`. `out_sample` holds its value until the next result.
- R8: `in_valid` asserted while a sample is being processed is ignored. It produces no extra output and leaves the filter history untouched.
- R9: A coefficient or gain write made while a sample is being processed is dropped. The next sample still uses the old value.
- R10: Reset clears every section's input and output history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 24 | Signed input sample |
| cfg_we | input | 1 | Write strobe for coefficient and gain registers |
| cfg_addr | input | 5 | Register address (5*section+index, gain at 20) |
| cfg_wdata | input | 20 | Signed fractional write data |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 24 | Signed filtered sample |

## Verification
The bench builds the engine with its defaults: 24-bit samples, 20-bit coefficients, four sections and a 48-bit accumulator. With these widths, a full-scale negative sample under a gain of -1 drives the gain stage into positive saturation. A coefficient near +1 in the offset feed-forward slot roughly doubles the section gain, which makes saturation inside the cascade reachable. The four-section depth fixes a 22-edge latency window, and the bench uses it to land an input strobe and a register write at a known point mid-computation. Results are compared against a bit-exact model of the equations above. Stimuli include impulses, steps and random streams under both mild and extreme coefficient sets.

// File: rtl/biq_pkg.sv
package biq_pkg;
  // coefficients per section
  localparam int TAPS = 5;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SCALE = 2'd1,
    PH_SECT  = 2'd2,
    PH_DONE  = 2'd3
  } biq_phase_e;

  // slot index inside a section; the slot order is decoded by the datapath
  typedef enum logic [2:0] {
    K_B2   = 3'd0,
    K_B0M1 = 3'd1,
    K_A2   = 3'd2,
    K_A1H  = 3'd3,
    K_B1H  = 3'd4
  } biq_kidx_e;
endpackage

// File: rtl/biq_coef_bank.sv
module biq_coef_bank #(
  parameter int NSEC   = 4,
  parameter int CW     = 20,
  parameter int ADDR_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     busy_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [CW-1:0]            wdata_i,
  input  logic [ADDR_W-1:0]        raddr_i,
  output logic signed [CW-1:0]     rdata_o,
  output logic signed [CW-1:0]     scale_o
);
  localparam int NCOEF = NSEC * biq_pkg::TAPS;

  logic [NCOEF-1:0][CW-1:0] coef_q;
  logic [CW-1:0]            scale_q;
  logic                     wr_ok;

  assign wr_ok = we_i && !busy_i;

  for (genvar g = 0; g < NCOEF; g++) begin : g_coef
    logic wen;
    assign wen = wr_ok && (waddr_i == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   coef_q[g] <= '0;
      else if (wen) coef_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     scale_q <= '0;
    else if (wr_ok && waddr_i == ADDR_W'(NCOEF))    scale_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCOEF; i++)
      if (raddr_i == ADDR_W'(i)) rdata_o = $signed(coef_q[i]);
  end

  assign scale_o = $signed(scale_q);

  // R9
  frozen_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(coef_q) && $stable(scale_q)));
endmodule

// File: rtl/biq_mac.sv
module biq_mac #(
  parameter int MA = 21,
  parameter int MB = 24,
  parameter int AW = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic                 clr_i,
  input  logic signed [AW-1:0] init_i,
  input  logic signed [MA-1:0] a_i,
  input  logic signed [MB-1:0] b_i,
  input  logic                 dbl_i,
  input  logic                 neg_i,
  output logic signed [AW-1:0] acc_o
);
  localparam int PW = MA + MB;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] term, base, acc_d, acc_q;
  logic signed [AW:0]   wide_sum;

  always_comb begin
    prod = a_i * b_i;
    term = {{(AW-PW){prod[PW-1]}}, prod};
    if (dbl_i) term = term <<< 1;
    if (neg_i) term = -term;
    base     = clr_i ? init_i : acc_q;
    acc_d    = base + term;
    wide_sum = {base[AW-1], base} + {term[AW-1], term};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (en_i)  acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  // R6
  acc_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (wide_sum[AW] == wide_sum[AW-1]));
endmodule

// File: rtl/biq_history.sv
module biq_history #(
  parameter int NSEC = 4,
  parameter int DW   = 24,
  parameter int SW   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_i,
  input  logic [SW-1:0]        usec_i,
  input  logic signed [DW-1:0] ux_i,
  input  logic signed [DW-1:0] uy_i,
  input  logic [SW-1:0]        rsec_i,
  output logic signed [DW-1:0] rx1_o,
  output logic signed [DW-1:0] rx2_o,
  output logic signed [DW-1:0] ry1_o,
  output logic signed [DW-1:0] ry2_o
);
  logic [NSEC-1:0][DW-1:0] x1_q, x2_q, y1_q, y2_q;

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    logic hit;
    assign hit = upd_i && (usec_i == SW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        x1_q[g] <= '0;
        x2_q[g] <= '0;
        y1_q[g] <= '0;
        y2_q[g] <= '0;
      end else if (hit) begin
        x2_q[g] <= x1_q[g];
        x1_q[g] <= ux_i;
        y2_q[g] <= y1_q[g];
        y1_q[g] <= uy_i;
      end
    end
  end

  always_comb begin
    rx1_o = '0;
    rx2_o = '0;
    ry1_o = '0;
    ry2_o = '0;
    for (int i = 0; i < NSEC; i++) begin
      if (rsec_i == SW'(i)) begin
        rx1_o = $signed(x1_q[i]);
        rx2_o = $signed(x2_q[i]);
        ry1_o = $signed(y1_q[i]);
        ry2_o = $signed(y2_q[i]);
      end
    end
  end
endmodule

// File: rtl/biq_cascade.sv
module biq_cascade import biq_pkg::*; #(
  parameter int DW   = 24,
  parameter int CW   = 20,
  parameter int NSEC = 4,
  parameter int AW   = 48,
  localparam int ADDR_W = $clog2(NSEC * TAPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_sample,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CW-1:0]     cfg_wdata,
  output logic              out_valid,
  output logic [DW-1:0]     out_sample
);
  localparam int FRAC    = CW - 1;
  localparam int SW      = (NSEC > 1) ? $clog2(NSEC) : 1;
  localparam int MA      = CW + 1;
  localparam int LATENCY = TAPS * NSEC + 2;
  localparam int LW      = $clog2(LATENCY + 2) + 1;
  localparam logic signed [AW-1:0] SAT_HI = AW'((64'sd1 <<< (DW - 1)) - 64'sd1);
  localparam logic signed [AW-1:0] SAT_LO = -SAT_HI - AW'(1);

  biq_phase_e          phase_q, phase_d;
  logic [SW-1:0]       sec_q, sec_d;
  logic [2:0]          tap_q, tap_d;
  logic signed [DW-1:0] xin_q, xin_d, curx_q, curx_d, dout_q, dout_d;
  logic                ov_q, ov_d;

  logic                busy;
  logic signed [AW-1:0] acc;
  logic signed [DW-1:0] x_now;
  logic signed [CW-1:0] coef, scale;
  logic [ADDR_W-1:0]   coef_addr;
  biq_kidx_e           kidx;
  logic signed [MA-1:0] mul_a;
  logic signed [DW-1:0] mul_b;
  logic signed [AW-1:0] init;
  logic                mac_en, clr, dbl, neg;
  logic                upd;
  logic [SW-1:0]       usec;
  logic signed [DW-1:0] rx1, rx2, ry1, ry2;

  function automatic logic signed [DW-1:0] sat_fn(input logic signed [AW-1:0] v);
    logic signed [AW-1:0] s;
    s = v >>> FRAC;
    if (s > SAT_HI)      s = SAT_HI;
    else if (s < SAT_LO) s = SAT_LO;
    return s[DW-1:0];
  endfunction

  assign busy  = (phase_q != PH_IDLE);
  assign x_now = sat_fn(acc);

  biq_coef_bank #(.NSEC(NSEC), .CW(CW), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .we_i(cfg_we),
    .waddr_i(cfg_addr), .wdata_i(cfg_wdata), .raddr_i(coef_addr),
    .rdata_o(coef), .scale_o(scale));

  biq_history #(.NSEC(NSEC), .DW(DW), .SW(SW)) u_hist (
    .clk(clk), .rst_n(rst_n), .upd_i(upd), .usec_i(usec),
    .ux_i(curx_q), .uy_i(x_now), .rsec_i(sec_q),
    .rx1_o(rx1), .rx2_o(rx2), .ry1_o(ry1), .ry2_o(ry2));

  biq_mac #(.MA(MA), .MB(DW), .AW(AW)) u_mac (
    .clk(clk), .rst_n(rst_n), .en_i(mac_en), .clr_i(clr), .init_i(init),
    .a_i(mul_a), .b_i(mul_b), .dbl_i(dbl), .neg_i(neg), .acc_o(acc));

  // operand selection: tap order b0-1, b1/2, b2, a1/2, a2
  always_comb begin
    case (tap_q)
      3'd0:    kidx = K_B0M1;
      3'd1:    kidx = K_B1H;
      3'd2:    kidx = K_B2;
      3'd3:    kidx = K_A1H;
      default: kidx = K_A2;
    endcase
    coef_addr = ADDR_W'(int'(sec_q) * TAPS + int'(kidx));
    mac_en    = (phase_q == PH_SCALE) || (phase_q == PH_SECT);
    init      = '0;
    dbl       = 1'b0;
    neg       = 1'b0;
    clr       = 1'b0;
    mul_a     = $signed({coef[CW-1], coef});
    mul_b     = x_now;
    if (phase_q == PH_SCALE) begin
      mul_a = -$signed({scale[CW-1], scale});
      mul_b = xin_q;
      clr   = 1'b1;
      neg   = 1'b1;
    end else begin
      case (tap_q)
        3'd0: begin
          clr  = 1'b1;
          init = $signed({{(AW-DW){x_now[DW-1]}}, x_now}) <<< FRAC;
        end
        3'd1: begin mul_b = rx1; dbl = 1'b1; end
        3'd2: mul_b = rx2;
        3'd3: begin mul_b = ry1; dbl = 1'b1; neg = 1'b1; end
        default: begin mul_b = ry2; neg = 1'b1; end
      endcase
    end
  end

  // history of the previous section updates while the next one starts
  always_comb begin
    upd  = ((phase_q == PH_SECT) && (tap_q == 3'd0) && (sec_q != '0)) ||
           (phase_q == PH_DONE);
    usec = (phase_q == PH_DONE) ? SW'(NSEC - 1) : sec_q - SW'(1);
  end

  // next state
  always_comb begin
    phase_d = phase_q;
    sec_d   = sec_q;
    tap_d   = tap_q;
    xin_d   = xin_q;
    curx_d  = curx_q;
    dout_d  = dout_q;
    ov_d    = 1'b0;
    case (phase_q)
      PH_IDLE: if (in_valid) begin
        xin_d   = $signed(in_sample);
        phase_d = PH_SCALE;
      end
      PH_SCALE: begin
        phase_d = PH_SECT;
        sec_d   = '0;
        tap_d   = '0;
      end
      PH_SECT: begin
        if (tap_q == 3'd0) curx_d = x_now;
        if (tap_q == 3'(TAPS - 1)) begin
          tap_d = '0;
          if (sec_q == SW'(NSEC - 1)) phase_d = PH_DONE;
          else                        sec_d   = sec_q + SW'(1);
        end else begin
          tap_d = tap_q + 3'd1;
        end
      end
      default: begin
        dout_d  = x_now;
        ov_d    = 1'b1;
        phase_d = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sec_q   <= '0;
      tap_q   <= '0;
      xin_q   <= '0;
      curx_q  <= '0;
      dout_q  <= '0;
      ov_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      sec_q   <= sec_d;
      tap_q   <= tap_d;
      xin_q   <= xin_d;
      curx_q  <= curx_d;
      dout_q  <= dout_d;
      ov_q    <= ov_d;
    end
  end

  assign out_valid  = ov_q;
  assign out_sample = dout_q;

  // latency observer
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lat_q <= '0;
    else if (!busy && in_valid)          lat_q <= LW'(1);
    else if (ov_q)                       lat_q <= '0;
    else if (lat_q != '0)                lat_q <= lat_q + LW'(1);
  end

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |-> (lat_q == LW'(LATENCY + 1)));

  // R7
  ov_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |=> !ov_q);

  // R5
  seq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sec_q) < NSEC) && (int'(tap_q) < TAPS));

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid) |=> $stable(xin_q));
endmodule

// File: tb/biq_cascade_test.sv
module biq_cascade_test;
  localparam int NS  = 4;
  localparam int LAT = 5 * NS + 2;
  localparam int VEC_N = 8;
  localparam int VIN  [VEC_N] = '{1000, 0, 8388607, -8388608, -1, 123456, -5000000, 4194304};
  localparam int VEXP [VEC_N] = '{-1000, 0, -8388607, 8388607, 1, -123456, 5000000, -4194304};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_sample;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [19:0] cfg_wdata;
  logic        out_valid;
  logic [23:0] out_sample;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  longint m_cf [NS][5];
  longint m_sc;
  longint mx1 [NS], mx2 [NS], my1 [NS], my2 [NS];
  logic [19:0] saved [21];

  always #2 clk = ~clk;

  biq_cascade uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_sample(out_sample));

  function automatic longint sat24(input longint v);
    if (v > 64'sd8388607)  return 64'sd8388607;
    if (v < -64'sd8388608) return -64'sd8388608;
    return v;
  endfunction

  function automatic longint model_step(input longint smp);
    longint x, acc, y;
    x = sat24((-((-m_sc) * smp)) >>> 19);
    for (int s = 0; s < NS; s++) begin
      acc = (x <<< 19) + m_cf[s][1] * x + 2 * m_cf[s][4] * mx1[s] + m_cf[s][0] * mx2[s]
            - 2 * m_cf[s][3] * my1[s] - m_cf[s][2] * my2[s];
      y = sat24(acc >>> 19);
      mx2[s] = mx1[s]; mx1[s] = x;
      my2[s] = my1[s]; my1[s] = y;
      x = y;
    end
    return x;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < NS; s++) begin
      mx1[s] = 0; mx2[s] = 0; my1[s] = 0; my2[s] = 0;
      for (int k = 0; k < 5; k++) m_cf[s][k] = 0;
    end
    m_sc = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; cfg_we = 1'b0;
    in_sample = '0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  task automatic wr(input int addr, input logic [19:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr < 5 * NS)       m_cf[addr / 5][addr % 5] = longint'($signed(data));
    else if (addr == 5 * NS) m_sc = longint'($signed(data));
  endtask

  // mode 0: plain; mode 1: extra in_valid mid-run; mode 2: gain write mid-run
  task automatic run(input longint smp, input int mode, input longint side,
                     output longint got, output int lat);
    @(negedge clk);
    in_sample = smp[23:0]; in_valid = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      in_valid = 1'b0; cfg_we = 1'b0; lat++;
      if (lat == 6 && mode == 1) begin in_valid = 1'b1; in_sample = side[23:0]; end
      if (lat == 6 && mode == 2) begin cfg_we = 1'b1; cfg_addr = 5'd20; cfg_wdata = side[19:0]; end
    end while (!out_valid && lat < 100);
    in_valid = 1'b0; cfg_we = 1'b0;
    got = longint'($signed(out_sample));
    lat = lat - 1;
  endtask

  task automatic cmp_sample(input string req, input longint smp);
    longint got, exp;
    int lat;
    exp = model_step(smp);
    run(smp, 0, 0, got, lat);
    check(req, got, exp);
  endtask

  task automatic program_saved();
    for (int a = 0; a < 21; a++) wr(a, saved[a]);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    longint got, exp;
    int lat, extra;
    logic [23:0] held;

    do_reset();
    // R1 reset state and zero gain
    check("R1 out_valid after reset", longint'(out_valid), 0);
    check("R1 out_sample after reset", longint'(out_sample), 0);
    run(5000, 0, 0, got, lat);
    check("R1 zero gain gives zero output", got, 0);

    // R3 R6 R7 table walk: gain -1, pass-through sections
    wr(20, 20'h80000);
    for (int i = 0; i < VEC_N; i++) begin
      run(VIN[i], 0, 0, got, lat);
      check("R3/R6 table output", got, VEXP[i]);
      check("R7 latency", lat, LAT);
      void'(model_step(VIN[i]));
    end
    // R7 output holds between results
    held = out_sample;
    repeat (7) @(negedge clk);
    check("R7 out_sample held", longint'(out_sample), longint'(held));

    // R3 half gain with floor rounding
    wr(20, 20'hC0000);
    run(3, 0, 0, got, lat);     check("R3 half gain of 3", got, -2);
    run(-3, 0, 0, got, lat);    check("R3 half gain of -3", got, 1);
    void'(model_step(3)); void'(model_step(-3));

    // R2 R4 R5 mild random coefficients: impulse, step, random
    for (int a = 0; a < 20; a++) begin
      logic [19:0] r;
      r = 20'($urandom);
      saved[a] = 20'($signed(r) >>> 3);
    end
    saved[20] = {1'b1, 19'($urandom)};
    program_saved();
    cmp_sample("R4 impulse head", 8388607);
    for (int i = 0; i < 12; i++) cmp_sample("R5 impulse tail", 0);
    for (int i = 0; i < 12; i++) cmp_sample("R4 step", 1000000);
    for (int i = 0; i < 30; i++) cmp_sample("R5 random", longint'($signed(24'($urandom))));

    // R2 write above the gain address is ignored
    wr(25, 20'h7FFFF);
    wr(31, 20'h12345);
    for (int i = 0; i < 4; i++) cmp_sample("R2 out-of-map write ignored", longint'($signed(24'($urandom))));

    // R6 extreme coefficients force saturation inside the cascade
    for (int a = 0; a < 20; a++) wr(a, 20'($urandom));
    wr(1, 20'h7FFFF);
    wr(20, 20'h80000);
    cmp_sample("R6 saturating cascade", -8388608);
    for (int i = 0; i < 20; i++) cmp_sample("R6 saturating random", longint'($signed(24'($urandom))));

    // R8 in_valid while busy ignored
    exp = model_step(77777);
    run(77777, 1, -4000000, got, lat);
    check("R8 result with busy strobe", got, exp);
    extra = 0;
    repeat (40) begin @(negedge clk); if (out_valid) extra++; end
    check("R8 no extra output", extra, 0);
    cmp_sample("R8 history untouched", 123);

    // R9 gain write during computation dropped
    exp = model_step(-654321);
    run(-654321, 2, 0, got, lat);
    check("R9 busy write sample", got, exp);
    cmp_sample("R9 old gain still used", 2000000);

    // R10 reset clears history
    do_reset();
    program_saved();
    cmp_sample("R10 impulse after reset", 8388607);
    for (int i = 0; i < 6; i++) cmp_sample("R10 tail after reset", 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule